// File: doc/BRIEF.md
# Ethernet PHY management register file

This block models the management register set of a 10/100 Ethernet PHY, reached through a plain register port. The port has a 5-bit register number, 16-bit write data with a write strobe, and 16-bit read data that follows the address without a clock delay. A link-up input sets the link state that the computed registers report.

Most of the 32 registers are plain storage. Three read-only views are built from the link input and from the local advertisement register (number 4): the basic status (number 1), the link partner ability (number 5) and a speed/duplex diagnostic word (number 18). Together they make autonegotiation appear to finish at once, at the best mode the host advertises. Host software can therefore run its normal PHY bring-up sequence against this model. Serial management framing, line signalling and timers are outside the block.

Top module: `phy_mgmt_regs`

## Requirements
- R1: The 5-bit register number selects one of 32 registers, and every number from 0 to 31 can be written and addressed. For example, register 31 reads back a value written to it.
- R2: While rst_ni is low, and after it is released, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. Every other plain register reads 0x0000.
- R3: Register 1 reads 0x782C while link_up_i is 1, which sets bits 14, 13, 12 and 11 (speed and duplex abilities), bit 5 (autonegotiation complete), bit 3 (autonegotiation able) and bit 2 (link up). It reads 0x0000 while link_up_i is 0.
- R4: Register 5 reads 0x4001 OR (register 4 AND 0x01E0), whatever the state of link_up_i.
- R5: While link_up_i is 1, register 18 has bit 10 = reg4[7] OR reg4[8] (100 Mb/s advertised) and bit 11 = reg4[8] OR reg4[6] (full duplex advertised), with all other bits 0. It reads 0x0000 while link_up_i is 0.
- R6: A write with wr_en_i = 1 stores wdata_i at the rising clock edge. From the next cycle, a register other than 1, 5 and 18 reads back that value unchanged.
- R7: A write to register 1, 5 or 18 does not change what that register reads. The computed value is always returned.
- R8: A new value written to register 4 is reflected in registers 5 and 18 in the cycle after the write.
- R9: When wr_en_i is 0, wdata_i and addr_i change no stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | 1 = link is up |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 5 | Register number for both read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |

## Verification
The hardest case to reach is a stored word behind a computed view. A write to register 1, 5 or 18 lands in storage that the port can never read back. So the check is indirect: after such a write, the register must still return the value derived from the link and from register 4. The stimulus also steps register 4 through single-bit advertisement patterns and an all-ones word, and toggles the link. This separates each term of the diagnostic OR equations and the partner-ability mask.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] REG_CTRL    = 5'd0;
  localparam logic [ADDR_W-1:0] REG_STATUS  = 5'd1;
  localparam logic [ADDR_W-1:0] REG_ID_HI   = 5'd2;
  localparam logic [ADDR_W-1:0] REG_ID_LO   = 5'd3;
  localparam logic [ADDR_W-1:0] REG_ADV     = 5'd4;
  localparam logic [ADDR_W-1:0] REG_PARTNER = 5'd5;
  localparam logic [ADDR_W-1:0] REG_DIAG    = 5'd18;

  localparam logic [DATA_W-1:0] ADV_MODE_MASK = 16'h01E0;

  function automatic logic [DATA_W-1:0] reset_value(int unsigned idx);
    case (idx)
      int'(REG_CTRL):  return 16'h3100;
      int'(REG_ID_HI): return 16'h0300;
      int'(REG_ID_LO): return 16'hE400;
      int'(REG_ADV):   return 16'h01E1;
      default:         return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_store_o,
  output logic [DATA_W-1:0] adv_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= reset_value(g);
      else if (wr_en_i && addr_i == ADDR_W'(g))
        regs_q[g] <= wdata_i;
    end
  end

  assign rd_store_o = regs_q[addr_i];
  assign adv_o      = regs_q[REG_ADV];
endmodule

// File: rtl/phy_view_synth.sv
module phy_view_synth
  import phy_mgmt_pkg::*;
(
  input  logic              link_up_i,
  input  logic [DATA_W-1:0] adv_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] partner_o,
  output logic [DATA_W-1:0] diag_o
);
  logic adv_100, adv_full;

  // abilities 14..11, aneg complete 5, aneg able 3, link 2
  localparam logic [DATA_W-1:0] STATUS_UP = 16'h782C;

  assign adv_100  = adv_i[7] | adv_i[8];
  assign adv_full = adv_i[8] | adv_i[6];

  assign status_o  = link_up_i ? STATUS_UP : '0;
  assign partner_o = 16'h4001 | (adv_i & ADV_MODE_MASK);

  always_comb begin
    diag_o = '0;
    if (link_up_i) begin
      diag_o[10] = adv_100;
      diag_o[11] = adv_full;
    end
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic              wr_en_i,
  input  logic [4:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o
);
  logic [DATA_W-1:0] rd_store, adv, status_v, partner_v, diag_v;

  phy_reg_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rd_store_o (rd_store),
    .adv_o      (adv)
  );

  phy_view_synth u_view (
    .link_up_i (link_up_i),
    .adv_i     (adv),
    .status_o  (status_v),
    .partner_o (partner_v),
    .diag_o    (diag_v)
  );

  always_comb begin
    case (addr_i)
      REG_STATUS:  rdata_o = status_v;
      REG_PARTNER: rdata_o = partner_v;
      REG_DIAG:    rdata_o = diag_v;
      default:     rdata_o = rd_store;
    endcase
  end

  logic plain_addr;
  assign plain_addr = addr_i != REG_STATUS && addr_i != REG_PARTNER && addr_i != REG_DIAG;

  // R6: plain register returns last written word
  p_store_readback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && addr_i == $past(addr_i) && plain_addr) |-> rdata_o == $past(wdata_i));

  // R3: no status while link down
  p_status_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_STATUS && !link_up_i) |-> rdata_o == '0);

  // R4: partner ability mirrors advertised modes
  p_partner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_PARTNER) |-> (rdata_o[14] && rdata_o[0] && rdata_o[8:5] == adv[8:5]));

  // R5: diagnostics zero while link down
  p_diag_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_DIAG && !link_up_i) |-> rdata_o == '0);

  // R9: no strobe, no change to a plain register
  p_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && addr_i == $past(addr_i) && plain_addr && $past(plain_addr))
      |-> $stable(rdata_o));
endmodule

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  phy_mgmt_regs u_phy_mgmt_regs (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .link_up_i (link_up),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata)
  );

  // {req[4], wr[1], waddr[5], wdata[16], link[1], raddr[5], exp[16]}
  localparam int NV = 24;
  localparam logic [47:0] VEC [NV] = '{
    {4'd2, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd0,  16'h3100}, // R2
    {4'd2, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd2,  16'h0300}, // R2
    {4'd2, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd3,  16'hE400}, // R2
    {4'd2, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd4,  16'h01E1}, // R2
    {4'd2, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd6,  16'h0000}, // R2
    {4'd3, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd1,  16'h782C}, // R3
    {4'd4, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd5,  16'h41E1}, // R4
    {4'd5, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd18, 16'h0C00}, // R5
    {4'd6, 1'b1, 5'd7,  16'hA5A5, 1'b1, 5'd7,  16'hA5A5}, // R6
    {4'd1, 1'b1, 5'd31, 16'h1234, 1'b1, 5'd31, 16'h1234}, // R1
    {4'd8, 1'b1, 5'd4,  16'h0020, 1'b1, 5'd18, 16'h0000}, // R8
    {4'd8, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd5,  16'h4021}, // R8
    {4'd8, 1'b1, 5'd4,  16'h0040, 1'b1, 5'd18, 16'h0800}, // R8
    {4'd8, 1'b1, 5'd4,  16'h0080, 1'b1, 5'd18, 16'h0400}, // R8
    {4'd8, 1'b1, 5'd4,  16'h0100, 1'b1, 5'd18, 16'h0C00}, // R8
    {4'd4, 1'b1, 5'd4,  16'hFFFF, 1'b1, 5'd5,  16'h41E1}, // R4
    {4'd3, 1'b0, 5'd0,  16'h0000, 1'b0, 5'd1,  16'h0000}, // R3
    {4'd5, 1'b0, 5'd0,  16'h0000, 1'b0, 5'd18, 16'h0000}, // R5
    {4'd4, 1'b0, 5'd0,  16'h0000, 1'b0, 5'd5,  16'h41E1}, // R4
    {4'd7, 1'b1, 5'd5,  16'h0000, 1'b1, 5'd5,  16'h41E1}, // R7
    {4'd7, 1'b1, 5'd1,  16'h0000, 1'b1, 5'd1,  16'h782C}, // R7
    {4'd7, 1'b1, 5'd18, 16'hFFFF, 1'b1, 5'd18, 16'h0C00}, // R7
    {4'd6, 1'b1, 5'd0,  16'hBEEF, 1'b1, 5'd0,  16'hBEEF}, // R6
    {4'd9, 1'b0, 5'd7,  16'h0000, 1'b1, 5'd7,  16'hA5A5}  // R9
  };

  task automatic check(input int req, input logic [15:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL R%0d addr=%0d actual=%h expected=%h", req, addr, rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en   = VEC[i][43];
      addr    = VEC[i][42:38];
      wdata   = VEC[i][37:22];
      link_up = VEC[i][21];
      @(negedge clk);
      wr_en = 1'b0;
      addr  = VEC[i][20:16];
      #1 check(int'(VEC[i][47:44]), VEC[i][15:0]);
    end

    // R2: asynchronous reset restores defaults mid-run
    @(negedge clk);
    rst_n = 1'b0;
    addr  = 5'd7;
    #1 check(2, 16'h0000);
    addr = 5'd0;
    #1 check(2, 16'h3100);
    addr = 5'd4;
    #1 check(2, 16'h01E1);
    @(negedge clk);
    rst_n = 1'b1;
    addr  = 5'd31;
    #1 check(2, 16'h0000);
    // R5: defaults restored for diagnostic view
    addr = 5'd18;
    #1 check(5, 16'h0C00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule